// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block drives the memory bus of an 8-bit-data processor with a 32-bit address space while that processor executes a subroutine call or a subroutine return. A decoder pulses `start` one cycle before the opcode fetch. With the pulse it supplies the address of the opcode on `pc_in`, the current stack pointer on `sp_in`, and the sequence type on `kind`. The sequencer then owns the address, write-enable and write-data outputs until the next instruction fetch. At that point it raises `done` for one cycle and presents the new program counter and stack pointer.

A call is five bytes long: one opcode and a four-byte little-endian target. The call pushes a four-byte return marker onto a descending stack held in a single 256-byte page. The push happens after only the first operand byte has been fetched, and the marker equals the call address plus two. A return pulls the marker back. It then adds three, so that execution continues at the instruction after the call. The memory is synchronous: a byte addressed in one cycle appears on `din` in the next cycle.

Top module: `callret_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `addr`, `we`, `dout`, `done`, `pc_out` and `sp_out` are all zero.
- R2: For a call (`kind`=0) at address A, accepted at a clock edge, the following cycles present these addresses: A, A+1, four stack addresses, A+2, A+3, A+4, A+5, and then the target.
- R3: Stack address n is 0x100 + n. The four call writes go to SP, SP-1, SP-2 and SP-3. They carry A+2 with the most significant byte first. `we` is high in exactly those four cycles.
- R4: The call target is built from the bytes read at A+1, A+2, A+3 and A+4, least significant first. In the cycle that presents the target, `pc_out` equals the target and `sp_out` equals SP-4.
- R5: For a return (`kind`=1) at address A, the cycles present A, A+1, a dummy read at SP, and then reads at SP+1, SP+2, SP+3 and SP+4. `we` stays low throughout.
- R6: The pulled value P is built from the return's four stack reads, least significant first. After the pulls, one cycle presents A+4. The next cycle presents P+3, with `pc_out`=P+3 and `sp_out`=SP+4.
- R7: Stack pointer arithmetic wraps modulo 256, and every stack access stays in page one, both when pushing below 0 and when pulling above 0xFF.
- R8: `done` is high for exactly one cycle: the cycle that presents the next opcode fetch. `pc_out` and `sp_out` change only in that cycle. In idle cycles `addr` holds its value and `we` is low.
- R9: A `start` pulse that arrives while a sequence is running, before its `done` cycle, has no effect on the bus trace or the results.
- R10: All program-counter arithmetic (A+1 through A+5, A+2 as the marker, P+3) wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence; sampled at the rising edge |
| kind | input | 1 | 0 = call, 1 = return |
| pc_in | input | 32 | Address of the call or return opcode |
| sp_in | input | 8 | Stack pointer at start |
| din | input | 8 | Read data, one cycle after the address |
| addr | output | 32 | Memory address (registered) |
| we | output | 1 | Write enable (registered) |
| dout | output | 8 | Write data (registered) |
| done | output | 1 | One-cycle strobe at the next opcode fetch |
| pc_out | output | 32 | New program counter, valid from `done` |
| sp_out | output | 8 | New stack pointer, valid from `done` |

## Verification
A wrong step count or a misdecoded sequence type shows up on `addr` in the very cycle of the error. The bench compares every cycle of every sequence against an independent trace, so such a fault is caught at once. A byte captured into the wrong lane only appears in the final cycle, as a wrong target or a wrong P+3. It is caught there and also through the stack bytes that the bench memory records. Faults in stack wrap and address wrap are reached by directed cases at SP=0x01 and SP=0xFD and at A near 0xFFFFFFFF. Random call/return pairs check that every return lands exactly five bytes after its call.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic {
    K_CALL = 1'b0,
    K_RET  = 1'b1
  } seq_kind_e;
endpackage

// File: rtl/crs_fsm.sv
module crs_fsm
  import crs_pkg::*;
#(
  parameter int CALL_LAST = 10,
  parameter int RET_LAST  = 8,
  parameter int STEPW     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  seq_kind_e        kind_in,
  output logic             active_q,
  output logic [STEPW-1:0] step_q,
  output seq_kind_e        kind_q,
  output logic             accept,
  output logic             nxt_active,
  output logic [STEPW-1:0] nxt_step,
  output seq_kind_e        nxt_kind,
  output logic             nxt_last
);
  logic last_now;

  always_comb begin
    last_now = active_q &&
               (int'(step_q) == ((kind_q == K_RET) ? RET_LAST : CALL_LAST));
    accept   = start && (!active_q || last_now);
    nxt_active = active_q;
    nxt_step   = step_q;
    nxt_kind   = kind_q;
    if (accept) begin
      nxt_active = 1'b1;
      nxt_step   = '0;
      nxt_kind   = kind_in;
    end else if (last_now) begin
      nxt_active = 1'b0;
      nxt_step   = '0;
    end else if (active_q) begin
      nxt_step = step_q + STEPW'(1);
    end
    nxt_last = nxt_active &&
               (int'(nxt_step) == ((nxt_kind == K_RET) ? RET_LAST : CALL_LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      step_q   <= '0;
      kind_q   <= K_CALL;
    end else begin
      active_q <= nxt_active;
      step_q   <= nxt_step;
      kind_q   <= nxt_kind;
    end
  end
endmodule

// File: rtl/crs_bytecap.sv
module crs_bytecap #(
  parameter int DW = 8,
  parameter int NB = 4,
  parameter int LW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [LW-1:0]    cap_lane,
  input  logic [DW-1:0]    din,
  output logic [NB*DW-1:0] word_now
);
  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_lane
      logic [DW-1:0] lane_q;
      logic          hit;
      assign hit = cap_en && (cap_lane == LW'(gi));
      always_ff @(posedge clk) begin
        if (rst)      lane_q <= '0;
        else if (hit) lane_q <= din;
      end
      assign word_now[gi*DW +: DW] = hit ? din : lane_q;
    end
  endgenerate
endmodule

// File: rtl/crs_busgen.sv
module crs_busgen
  import crs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 8,
  parameter int NB         = 4,
  parameter int SPW        = 8,
  parameter int STEPW      = 4,
  parameter int STACK_PAGE = 1,
  parameter int CALL_LEN   = 5
) (
  input  logic             nxt_active,
  input  logic [STEPW-1:0] nxt_step,
  input  seq_kind_e        nxt_kind,
  input  logic [AW-1:0]    base,
  input  logic [SPW-1:0]   sp,
  input  logic [AW-1:0]    word_now,
  input  logic [AW-1:0]    addr_hold,
  output logic [AW-1:0]    addr_n,
  output logic             we_n,
  output logic [DW-1:0]    dout_n,
  output logic [AW-1:0]    pc_n,
  output logic [SPW-1:0]   sp_n
);
  localparam int PUSH0     = 2;
  localparam int OPR1      = PUSH0 + NB;
  localparam int RECV      = 2 * NB + 1;
  localparam int CALL_LAST = 2 * NB + 2;
  localparam int PULL0     = 3;
  localparam int RET_SKIP  = PULL0 + NB;
  localparam int RET_LAST  = RET_SKIP + 1;

  function automatic logic [AW-1:0] stk(input logic [SPW-1:0] p);
    return (AW'(STACK_PAGE) << SPW) | AW'(p);
  endfunction

  logic [AW-1:0] marker;
  int            s;

  always_comb begin
    marker = base + AW'(2);
    s      = int'(nxt_step);
    addr_n = addr_hold;
    we_n   = 1'b0;
    dout_n = '0;
    if (nxt_active) begin
      if (s == 0) addr_n = base;
      else if (s == 1) addr_n = base + AW'(1);
      else if (nxt_kind == K_CALL) begin
        for (int k = 0; k < NB; k++) begin
          if (s == PUSH0 + k) begin
            addr_n = stk(sp - SPW'(k));
            we_n   = 1'b1;
            dout_n = marker[(NB-1-k)*DW +: DW];
          end
        end
        for (int j = 0; j < NB - 1; j++) begin
          if (s == OPR1 + j) addr_n = base + AW'(2 + j);
        end
        if (s == RECV)      addr_n = base + AW'(NB + 1);
        if (s == CALL_LAST) addr_n = word_now;
      end else begin
        if (s == 2) addr_n = stk(sp);
        for (int k = 0; k < NB; k++) begin
          if (s == PULL0 + k) addr_n = stk(sp + SPW'(k + 1));
        end
        if (s == RET_SKIP) addr_n = base + AW'(NB);
        if (s == RET_LAST) addr_n = word_now + AW'(CALL_LEN - 2);
      end
    end
    pc_n = (nxt_kind == K_CALL) ? word_now : word_now + AW'(CALL_LEN - 2);
    sp_n = (nxt_kind == K_CALL) ? sp - SPW'(NB) : sp + SPW'(NB);
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import crs_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 8,
  parameter int SPW        = 8,
  parameter int STACK_PAGE = 1,
  parameter int CALL_LEN   = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           kind,
  input  logic [AW-1:0]  pc_in,
  input  logic [SPW-1:0] sp_in,
  input  logic [DW-1:0]  din,
  output logic [AW-1:0]  addr,
  output logic           we,
  output logic [DW-1:0]  dout,
  output logic           done,
  output logic [AW-1:0]  pc_out,
  output logic [SPW-1:0] sp_out
);
  localparam int NB        = AW / DW;
  localparam int CALL_LAST = 2 * NB + 2;
  localparam int RET_LAST  = NB + 4;
  localparam int STEPW     = $clog2(CALL_LAST + 1);
  localparam int LW        = (NB > 1) ? $clog2(NB) : 1;

  logic             active_q, accept, nxt_active, nxt_last;
  logic [STEPW-1:0] step_q, nxt_step;
  seq_kind_e        kind_q, nxt_kind;
  logic [AW-1:0]    base_q, base_use, word_now, addr_n, pc_n;
  logic [SPW-1:0]   sp_q, sp_use, sp_n;
  logic             we_n, cap_en;
  logic [DW-1:0]    dout_n;
  logic [LW-1:0]    cap_lane;

  crs_fsm #(
    .CALL_LAST(CALL_LAST), .RET_LAST(RET_LAST), .STEPW(STEPW)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .kind_in(seq_kind_e'(kind)),
    .active_q(active_q), .step_q(step_q), .kind_q(kind_q), .accept(accept),
    .nxt_active(nxt_active), .nxt_step(nxt_step), .nxt_kind(nxt_kind),
    .nxt_last(nxt_last)
  );

  // Lane select for the byte arriving on din this cycle
  always_comb begin
    int s;
    s        = int'(step_q);
    cap_en   = 1'b0;
    cap_lane = '0;
    if (active_q) begin
      if (kind_q == K_CALL) begin
        if (s == 2) begin
          cap_en = 1'b1;
        end else if (s >= NB + 3 && s <= 2 * NB + 1) begin
          cap_en   = 1'b1;
          cap_lane = LW'(s - (NB + 2));
        end
      end else if (s >= 4 && s <= NB + 3) begin
        cap_en   = 1'b1;
        cap_lane = LW'(s - 4);
      end
    end
  end

  crs_bytecap #(.DW(DW), .NB(NB), .LW(LW)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_lane(cap_lane),
    .din(din), .word_now(word_now)
  );

  assign base_use = accept ? pc_in : base_q;
  assign sp_use   = accept ? sp_in : sp_q;

  crs_busgen #(
    .AW(AW), .DW(DW), .NB(NB), .SPW(SPW), .STEPW(STEPW),
    .STACK_PAGE(STACK_PAGE), .CALL_LEN(CALL_LEN)
  ) u_bus (
    .nxt_active(nxt_active), .nxt_step(nxt_step), .nxt_kind(nxt_kind),
    .base(base_use), .sp(sp_use), .word_now(word_now), .addr_hold(addr),
    .addr_n(addr_n), .we_n(we_n), .dout_n(dout_n), .pc_n(pc_n), .sp_n(sp_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      sp_q   <= '0;
      addr   <= '0;
      we     <= 1'b0;
      dout   <= '0;
      done   <= 1'b0;
      pc_out <= '0;
      sp_out <= '0;
    end else begin
      if (accept) begin
        base_q <= pc_in;
        sp_q   <= sp_in;
      end
      addr <= addr_n;
      we   <= we_n;
      dout <= dout_n;
      done <= nxt_last;
      if (nxt_last) begin
        pc_out <= pc_n;
        sp_out <= sp_n;
      end
    end
  end
endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
  parameter int AW         = 32,
  parameter int SPW        = 8,
  parameter int NB         = 4,
  parameter int STACK_PAGE = 1
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  addr,
  input logic           we,
  input logic           done,
  input logic [AW-1:0]  pc_out,
  input logic [SPW-1:0] sp_out
);
  int run_q;
  always_ff @(posedge clk) begin
    if (rst)     run_q <= 0;
    else if (we) run_q <= run_q + 1;
    else         run_q <= 0;
  end

  a_r3_we_in_page: assert property (@(posedge clk) disable iff (rst)
    we |-> addr[AW-1:SPW] == (AW-SPW)'(STACK_PAGE));
  a_r3_push_descends: assert property (@(posedge clk) disable iff (rst)
    (we && $past(we)) |-> addr[SPW-1:0] == $past(addr[SPW-1:0]) - SPW'(1));
  a_r3_push_run: assert property (@(posedge clk) disable iff (rst)
    we |-> run_q < NB);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_no_write: assert property (@(posedge clk) disable iff (rst)
    done |-> !we);
  a_r8_pc_on_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pc_out));
  a_r8_sp_on_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sp_out));
endmodule

bind callret_seq callret_seq_chk #(
  .AW(AW), .SPW(SPW), .NB(NB), .STACK_PAGE(STACK_PAGE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .done(done),
  .pc_out(pc_out), .sp_out(sp_out)
);

// File: tb/callret_seq_tb.sv
module callret_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        kind = 1'b0;
  logic [31:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  din = '0;
  logic [31:0] addr, pc_out;
  logic        we, done;
  logic [7:0]  dout, sp_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [logic [31:0]];

  callret_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .kind(kind), .pc_in(pc_in),
    .sp_in(sp_in), .din(din), .addr(addr), .we(we), .dout(dout),
    .done(done), .pc_out(pc_out), .sp_out(sp_out)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    din <= mem.exists(addr) ? mem[addr] : 8'h00;
    if (we) mem[addr] = dout;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stk(logic [7:0] p);
    return 32'h100 | {24'h0, p};
  endfunction

  function automatic logic [31:0] call_addr(logic [31:0] a, logic [7:0] sp,
                                            logic [31:0] tgt, int k);
    if (k <= 1) return a + k;
    if (k <= 5) return stk(sp - 8'(k - 2));
    if (k <= 9) return a + 32'(k - 4);
    return tgt;
  endfunction

  function automatic logic [31:0] ret_addr(logic [31:0] a, logic [7:0] sp,
                                           logic [31:0] p, int k);
    if (k <= 1) return a + k;
    if (k <= 6) return stk(sp + 8'(k - 2));
    if (k == 7) return a + 32'd4;
    return p + 32'd3;
  endfunction

  task automatic run_call(logic [31:0] a, logic [7:0] sp, logic [31:0] tgt, bit poke);
    logic [31:0] mk;
    mk = a + 32'd2;
    mem[a] = 8'h20;
    for (int j = 0; j < 4; j++) mem[a + 32'(1 + j)] = tgt[8*j +: 8];
    start = 1'b1; kind = 1'b0; pc_in = a; sp_in = sp;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= 10; k++) begin
      chk((k >= 2 && k <= 5) ? "R3" : (k == 10 ? "R4" : "R2"),
          $sformatf("call addr k=%0d", k), addr, call_addr(a, sp, tgt, k));
      chk("R3", $sformatf("call we k=%0d", k), {31'h0, we},
          {31'h0, (k >= 2 && k <= 5)});
      if (k >= 2 && k <= 5)
        chk("R3", $sformatf("call dout k=%0d", k), {24'h0, dout},
            {24'h0, mk[8*(5-k) +: 8]});
      chk("R8", $sformatf("call done k=%0d", k), {31'h0, done}, {31'h0, (k == 10)});
      if (k == 10) begin
        chk("R4", "call pc_out", pc_out, tgt);
        chk("R7", "call sp_out", {24'h0, sp_out}, {24'h0, sp - 8'd4});
      end
      if (poke && k == 4) begin  // R9: start while busy must be ignored
        start = 1'b1; kind = 1'b1; pc_in = 32'h5555_0000; sp_in = 8'h33;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++)
      chk("R7", $sformatf("stack byte %0d", k), {24'h0, mem[stk(sp - 8'(k))]},
          {24'h0, mk[8*(3-k) +: 8]});
    chk("R8", "idle done", {31'h0, done}, 32'h0);
    chk("R8", "idle addr hold", addr, tgt);
  endtask

  task automatic run_ret(logic [31:0] a, logic [7:0] sp, logic [31:0] p);
    mem[a] = 8'h60;
    start = 1'b1; kind = 1'b1; pc_in = a; sp_in = sp;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= 8; k++) begin
      chk(k >= 7 ? "R6" : "R5", $sformatf("ret addr k=%0d", k), addr,
          ret_addr(a, sp, p, k));
      chk("R5", $sformatf("ret we k=%0d", k), {31'h0, we}, 32'h0);
      chk("R8", $sformatf("ret done k=%0d", k), {31'h0, done}, {31'h0, (k == 8)});
      if (k == 8) begin
        chk("R6", "ret pc_out", pc_out, p + 32'd3);
        chk("R7", "ret sp_out", {24'h0, sp_out}, {24'h0, sp + 8'd4});
      end
      @(negedge clk);
    end
    chk("R8", "ret idle we", {31'h0, we}, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] a, t;
    logic [7:0]  s;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1", "reset addr", addr, 32'h0);
    chk("R1", "reset we/done", {30'h0, we, done}, 32'h0);
    chk("R1", "reset pc/sp", pc_out ^ {24'h0, sp_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "first cycle after reset addr", addr, 32'h0);
    chk("R1", "first cycle dout", {24'h0, dout}, 32'h0);

    // R2 R3 R4: plain call, then return to following instruction (R6)
    run_call(32'h0000_0203, 8'hFF, 32'h1234_5678, 1'b0);
    run_ret(32'h1234_5678, 8'hFB, 32'h0000_0205);
    // R7: stack wrap downwards on push, upwards on pull
    run_call(32'h0000_4000, 8'h01, 32'h0000_9000, 1'b0);
    run_ret(32'h0000_9000, 8'hFD, 32'h0000_4002);
    // R10: address wrap around 2^32
    run_call(32'hFFFF_FFFE, 8'h80, 32'h0001_0000, 1'b0);
    run_ret(32'hFFFF_FFFD, 8'h7C, 32'h0000_0000);
    // R9: start pulse in mid-sequence ignored
    run_call(32'h0002_0000, 8'h40, 32'hCAFE_0010, 1'b1);
    run_ret(32'hCAFE_0010, 8'h3C, 32'h0002_0002);

    for (int i = 0; i < 20; i++) begin
      a = $urandom | 32'h0001_0000;
      t = $urandom | 32'h0001_0000;
      s = 8'($urandom);
      repeat ($urandom % 3) @(negedge clk);
      run_call(a, s, t, 1'b0);
      run_ret(t, s - 8'd4, a + 32'd2);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule